// File: doc/BRIEF.md
# Prioritized Auto-Acknowledging Interrupt Controller

This block takes a parameterized set of level-sensitive interrupt request lines and serves a parameterized number of CPUs. Every CPU has its own 32-bit register port. Each line has three pieces of state: a mask bit, a software-trigger bit and a routing mask that lists the CPUs allowed to take it. A line requests service when its hardware input or its software bit is high. It is eligible for a CPU when it is requesting, it is unmasked, and it is routed to that CPU.

A CPU learns which interrupt to serve by reading its event register. The read returns the lowest-numbered line that is eligible for that CPU. The same read masks that line, so an interrupt is taken by reading it, and software re-enables the line by unmasking it when the handler is done. If several CPUs read their event registers in the same cycle, they are served in order of CPU index and never receive the same line. Each CPU also has an interrupt output that stays high while anything is eligible for it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A read of byte address 0x0000 returns the number of implemented lines in bits 15:0 and zero in bits 31:16. The default is 64, giving 0x00000040.
- R2: After reset every line is masked, every software bit is clear and every routing mask is zero. Every interrupt output is low and an event read returns 0.
- R3: Line n lives in bit n%32 of word n>>5. A write to 0x0100+4*word sets the mask bits where the data is 1, and a write to 0x0180+4*word clears them. Zero data bits change nothing. A read of either address returns the current mask word.
- R4: Software bits use the same word layout at 0x0200 (write 1 to set) and 0x0280 (write 1 to clear), and both addresses read back the software word. A line requests service while its hardware input OR its software bit is high. Requests are level-sensitive: a line whose input drops before it is taken is no longer reported.
- R5: The routing mask of line n is at 0x1000+4*n. Bit c of that word permits CPU c, and a read returns the mask.
- R6: A read of 0x0004 returns the event word for the eligible line with the lowest number. Bits 31:16 hold type 1 and bits 15:0 hold the line number. The word is 0 when no line is eligible. Lines not routed to the reading CPU are never returned.
- R7: An event read that returns a line sets that line's mask bit at the same clock edge. The line stays masked, even while its input remains high, until its mask is cleared.
- R8: An interrupt output is high exactly while at least one requesting, unmasked line is routed to that CPU.
- R9: When several CPUs read the event register in the same cycle, the lower CPU index gets its winner first. Each higher CPU gets the next eligible line, excluding lines already given out in that cycle, or 0 if none is left. Two CPUs never receive the same line.
- R10: Read data appears on a CPU's read-data port one cycle after the read strobe and holds until that CPU's next read. Writes take effect at the strobe's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_LINES | Level-sensitive hardware request lines |
| bus_sel | input | NUM_CPUS | Per-CPU access strobe |
| bus_wr | input | NUM_CPUS | Per-CPU write enable (0 = read) |
| bus_addr | input | 16*NUM_CPUS | Per-CPU byte address, CPU c in bits 16c+15:16c |
| bus_wdata | input | 32*NUM_CPUS | Per-CPU write data |
| bus_rdata | output | 32*NUM_CPUS | Per-CPU registered read data |
| irq_out | output | NUM_CPUS | Per-CPU interrupt output |

## Verification
A read result is due on the read-data port at the first falling edge after the strobe's rising edge. The bench samples it there, and the checks for hold behaviour sample again over later idle cycles. The mask side effect of an event read lands at the same rising edge, so the interrupt outputs and mask read-backs are checked from the next falling edge onward. Hardware line changes reach the interrupt outputs without a register, so they are checked at the falling edge after the bench moves the line. Simultaneous event reads are issued at one edge and both results are compared at the following falling edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam logic [15:0] OFS_INFO     = 16'h0000;
   localparam logic [15:0] OFS_EVENT    = 16'h0004;
   localparam logic [15:0] OFS_MASK_SET = 16'h0100;
   localparam logic [15:0] OFS_MASK_CLR = 16'h0180;
   localparam logic [15:0] OFS_SOFT_SET = 16'h0200;
   localparam logic [15:0] OFS_SOFT_CLR = 16'h0280;
   localparam logic [3:0]  TGT_PAGE     = 4'h1;
   localparam logic [15:0] EVT_TYPE_HW  = 16'd1;
endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
   parameter int W     = 64,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx,
   output logic [W-1:0]     onehot
);
   assign found  = |vec;
   assign onehot = vec & (~vec + W'(1));

   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irqc_claim_chain.sv
module irqc_claim_chain #(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 2,
   parameter int LINE_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0]          ready,
   input  logic [NUM_CPUS*NUM_LINES-1:0] route_flat,
   input  logic [NUM_CPUS-1:0]           take_req,
   output logic [NUM_CPUS-1:0]           win_found,
   output logic [NUM_CPUS*LINE_W-1:0]    win_idx_flat,
   output logic [NUM_LINES-1:0]          ack_vec,
   output logic [NUM_CPUS-1:0]           irq_req
);
   logic [NUM_CPUS:0][NUM_LINES-1:0] taken;
   assign taken[0] = '0;

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic [NUM_LINES-1:0] routed, cand, hot;
      assign routed     = ready & route_flat[c*NUM_LINES +: NUM_LINES];
      assign irq_req[c] = |routed;
      assign cand       = routed & ~taken[c];
      irqc_prio_enc #(.W(NUM_LINES), .IDX_W(LINE_W)) u_enc (
         .vec    (cand),
         .found  (win_found[c]),
         .idx    (win_idx_flat[c*LINE_W +: LINE_W]),
         .onehot (hot)
      );
      assign taken[c+1] = taken[c] | (take_req[c] ? hot : '0);
   end

   assign ack_vec = taken[NUM_CPUS];
endmodule

// File: rtl/irqc_line_regs.sv
module irqc_line_regs #(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 2,
   parameter int LINE_W    = $clog2(NUM_LINES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_LINES-1:0]          mask_set,
   input  logic [NUM_LINES-1:0]          mask_clr,
   input  logic [NUM_LINES-1:0]          soft_set,
   input  logic [NUM_LINES-1:0]          soft_clr,
   input  logic [NUM_LINES-1:0]          ack,
   input  logic [NUM_CPUS-1:0]           tgt_we,
   input  logic [NUM_CPUS*LINE_W-1:0]    tgt_line_flat,
   input  logic [NUM_CPUS*NUM_CPUS-1:0]  tgt_data_flat,
   output logic [NUM_LINES-1:0]          mask_q,
   output logic [NUM_LINES-1:0]          soft_q,
   output logic [NUM_CPUS*NUM_LINES-1:0] route_flat
);
   logic [NUM_LINES-1:0][NUM_CPUS-1:0] tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         soft_q <= '0;
         tgt_q  <= '0;
      end else begin
         mask_q <= (mask_q & ~mask_clr) | mask_set | ack;
         soft_q <= (soft_q & ~soft_clr) | soft_set;
         for (int c = 0; c < NUM_CPUS; c++) begin
            if (tgt_we[c])
               tgt_q[tgt_line_flat[c*LINE_W +: LINE_W]] <= tgt_data_flat[c*NUM_CPUS +: NUM_CPUS];
         end
      end
   end

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_rc
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_rl
         assign route_flat[c*NUM_LINES + l] = tgt_q[l][c];
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_LINES-1:0]       irq_line,
   input  logic [NUM_CPUS-1:0]        bus_sel,
   input  logic [NUM_CPUS-1:0]        bus_wr,
   input  logic [NUM_CPUS*16-1:0]     bus_addr,
   input  logic [NUM_CPUS*32-1:0]     bus_wdata,
   output logic [NUM_CPUS*32-1:0]     bus_rdata,
   output logic [NUM_CPUS-1:0]        irq_out
);
   localparam int LINE_W = $clog2(NUM_LINES);
   localparam int WORDS  = NUM_LINES / 32;

   if (NUM_LINES < 32 || NUM_LINES > 1024 || (NUM_LINES % 32) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of 32 between 32 and 1024");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > 32) begin : g_bad_cpus
      $error("NUM_CPUS must be between 1 and 32");
   end

   logic [NUM_LINES-1:0]          mask_w, soft_w, ready, ack_vec;
   logic [NUM_CPUS*NUM_LINES-1:0] route_w;
   logic [NUM_CPUS-1:0]           take_req, win_found, tgt_we;
   logic [NUM_CPUS*LINE_W-1:0]    win_idx, tgt_line;
   logic [NUM_CPUS*NUM_CPUS-1:0]  tgt_data;
   logic [NUM_CPUS-1:0][NUM_LINES-1:0] ms_v, mc_v, ss_v, sc_v;
   logic [NUM_LINES-1:0] ms_all, mc_all, ss_all, sc_all;

   assign ready = (irq_line | soft_w) & ~mask_w;

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_port
      logic [15:0]          addr;
      logic [31:0]          wd, rnext, mword, sword, tword;
      logic                 rd, wr, in_tgt;
      logic [4:0]           widx;
      logic [LINE_W-1:0]    tline;
      logic [NUM_LINES-1:0] wexp;
      logic [31:0]          rdata_q;

      assign addr   = bus_addr[c*16 +: 16];
      assign wd     = bus_wdata[c*32 +: 32];
      assign rd     = bus_sel[c] & ~bus_wr[c];
      assign wr     = bus_sel[c] & bus_wr[c];
      assign widx   = addr[6:2];
      assign tline  = addr[LINE_W+1:2];
      assign in_tgt = (addr[15:12] == TGT_PAGE) && ({1'b0, addr[11:2]} < 11'(NUM_LINES));

      always_comb begin
         wexp  = '0;
         mword = '0;
         sword = '0;
         tword = '0;
         for (int w = 0; w < WORDS; w++) begin
            if (widx == 5'(w)) begin
               wexp[w*32 +: 32] = wd;
               mword = mask_w[w*32 +: 32];
               sword = soft_w[w*32 +: 32];
            end
         end
         for (int l = 0; l < NUM_LINES; l++) begin
            if (tline == LINE_W'(l)) begin
               for (int k = 0; k < NUM_CPUS; k++) tword[k] = route_w[k*NUM_LINES + l];
            end
         end
      end

      assign ms_v[c] = (wr && addr[15:7] == OFS_MASK_SET[15:7]) ? wexp : '0;
      assign mc_v[c] = (wr && addr[15:7] == OFS_MASK_CLR[15:7]) ? wexp : '0;
      assign ss_v[c] = (wr && addr[15:7] == OFS_SOFT_SET[15:7]) ? wexp : '0;
      assign sc_v[c] = (wr && addr[15:7] == OFS_SOFT_CLR[15:7]) ? wexp : '0;

      assign tgt_we[c]                        = wr & in_tgt;
      assign tgt_line[c*LINE_W +: LINE_W]     = tline;
      assign tgt_data[c*NUM_CPUS +: NUM_CPUS] = wd[NUM_CPUS-1:0];
      assign take_req[c] = rd && (addr[15:2] == OFS_EVENT[15:2]);

      always_comb begin
         rnext = '0;
         if (addr[15:2] == OFS_INFO[15:2])
            rnext = {16'h0, 16'(NUM_LINES)};
         else if (addr[15:2] == OFS_EVENT[15:2])
            rnext = win_found[c] ? {EVT_TYPE_HW, 16'(win_idx[c*LINE_W +: LINE_W])} : '0;
         else if (addr[15:7] == OFS_MASK_SET[15:7] || addr[15:7] == OFS_MASK_CLR[15:7])
            rnext = mword;
         else if (addr[15:7] == OFS_SOFT_SET[15:7] || addr[15:7] == OFS_SOFT_CLR[15:7])
            rnext = sword;
         else if (in_tgt)
            rnext = tword;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)  rdata_q <= '0;
         else if (rd) rdata_q <= rnext;
      end
      assign bus_rdata[c*32 +: 32] = rdata_q;
   end

   always_comb begin
      ms_all = '0; mc_all = '0; ss_all = '0; sc_all = '0;
      for (int c = 0; c < NUM_CPUS; c++) begin
         ms_all |= ms_v[c];
         mc_all |= mc_v[c];
         ss_all |= ss_v[c];
         sc_all |= sc_v[c];
      end
   end

   irqc_line_regs #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .LINE_W(LINE_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .mask_set      (ms_all),
      .mask_clr      (mc_all),
      .soft_set      (ss_all),
      .soft_clr      (sc_all),
      .ack           (ack_vec),
      .tgt_we        (tgt_we),
      .tgt_line_flat (tgt_line),
      .tgt_data_flat (tgt_data),
      .mask_q        (mask_w),
      .soft_q        (soft_w),
      .route_flat    (route_w)
   );

   irqc_claim_chain #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .LINE_W(LINE_W)) u_claim (
      .ready        (ready),
      .route_flat   (route_w),
      .take_req     (take_req),
      .win_found    (win_found),
      .win_idx_flat (win_idx),
      .ack_vec      (ack_vec),
      .irq_req      (irq_out)
   );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
   import irqc_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_CPUS  = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_CPUS-1:0]    bus_sel,
   input logic [NUM_CPUS-1:0]    bus_wr,
   input logic [NUM_CPUS*16-1:0] bus_addr,
   input logic [NUM_CPUS*32-1:0] bus_rdata,
   input logic [NUM_CPUS-1:0]    irq_out,
   input logic [NUM_LINES-1:0]   mask_q
);
   localparam int LINE_W = $clog2(NUM_LINES);

   logic rd0, evt0;
   assign rd0  = bus_sel[0] & ~bus_wr[0];
   assign evt0 = rd0 && (bus_addr[15:2] == OFS_EVENT[15:2]);

   // R6: event word is either empty or a type-1 word with an in-range line
   a_r6_event_format: assert property (@(posedge clk) disable iff (!rst_n)
      evt0 |=> (bus_rdata[31:0] == 32'h0) ||
               (bus_rdata[31:16] == EVT_TYPE_HW && bus_rdata[15:0] < 16'(NUM_LINES)));

   // R7: a returned line is masked right after the read
   a_r7_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
      evt0 |=> (bus_rdata[31:16] != EVT_TYPE_HW) || mask_q[bus_rdata[LINE_W-1:0]]);

   // R8: an empty event for the first CPU means its interrupt output was low
   a_r8_empty_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
      evt0 |=> (bus_rdata[31:0] != 32'h0) || !$past(irq_out[0]));

   // R10: read data holds while no read is issued
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd0 |=> $stable(bus_rdata[31:0]));

   if (NUM_CPUS >= 2) begin : g_pair
      logic evt1;
      assign evt1 = bus_sel[1] && !bus_wr[1] && (bus_addr[31:18] == OFS_EVENT[15:2]);
      // R9: simultaneous event reads never hand out one line twice
      a_r9_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
         (evt0 && evt1) |=> !(bus_rdata[31:16] == EVT_TYPE_HW &&
                              bus_rdata[31:0] == bus_rdata[63:32]));
   end
endmodule

bind prio_irq_ctrl irqc_checker #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .mask_q    (mask_w)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 64;
   localparam int NC = 2;

   typedef struct packed {
      logic [7:0]  cpu;
      logic        wr;
      logic [15:0] addr;
      logic [31:0] wdata;
      logic        chk;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t VEC [NV] = '{
      '{8'd0, 1'b0, 16'h0000, 32'h0, 1'b1, 32'h0000_0040, 8'd1},  // R1 info
      '{8'd0, 1'b0, 16'h0004, 32'h0, 1'b1, 32'h0000_0000, 8'd2},  // R2 empty event
      '{8'd0, 1'b0, 16'h0100, 32'h0, 1'b1, 32'hFFFF_FFFF, 8'd2},  // R2 mask w0
      '{8'd1, 1'b0, 16'h0104, 32'h0, 1'b1, 32'hFFFF_FFFF, 8'd2},  // R2 mask w1
      '{8'd0, 1'b0, 16'h0200, 32'h0, 1'b1, 32'h0000_0000, 8'd2},  // R2 soft
      '{8'd1, 1'b0, 16'h1014, 32'h0, 1'b1, 32'h0000_0000, 8'd2},  // R2 route line 5
      '{8'd0, 1'b1, 16'h1014, 32'h1, 1'b0, 32'h0, 8'd5},          // route line 5 -> cpu0
      '{8'd1, 1'b1, 16'h10A0, 32'h3, 1'b0, 32'h0, 8'd5},          // route line 40 -> both
      '{8'd0, 1'b1, 16'h100C, 32'h2, 1'b0, 32'h0, 8'd5},          // route line 3 -> cpu1
      '{8'd1, 1'b0, 16'h1014, 32'h0, 1'b1, 32'h0000_0001, 8'd5},  // R5
      '{8'd0, 1'b0, 16'h10A0, 32'h0, 1'b1, 32'h0000_0003, 8'd5},  // R5
      '{8'd0, 1'b1, 16'h0180, 32'h28, 1'b0, 32'h0, 8'd3},         // unmask 3,5
      '{8'd1, 1'b1, 16'h0184, 32'h100, 1'b0, 32'h0, 8'd3},        // unmask 40
      '{8'd0, 1'b0, 16'h0100, 32'h0, 1'b1, 32'hFFFF_FFD7, 8'd3},  // R3
      '{8'd1, 1'b0, 16'h0184, 32'h0, 1'b1, 32'hFFFF_FEFF, 8'd3},  // R3 clear alias
      '{8'd0, 1'b1, 16'h0200, 32'h20, 1'b0, 32'h0, 8'd4},         // soft line 5
      '{8'd1, 1'b1, 16'h0204, 32'h100, 1'b0, 32'h0, 8'd4},        // soft line 40
      '{8'd1, 1'b0, 16'h0200, 32'h0, 1'b1, 32'h0000_0020, 8'd4},  // R4
      '{8'd1, 1'b0, 16'h0004, 32'h0, 1'b1, 32'h0001_0028, 8'd6},  // R6 routing
      '{8'd1, 1'b0, 16'h0004, 32'h0, 1'b1, 32'h0000_0000, 8'd7},  // R7 taken
      '{8'd0, 1'b0, 16'h0004, 32'h0, 1'b1, 32'h0001_0005, 8'd6},  // R6
      '{8'd0, 1'b0, 16'h0100, 32'h0, 1'b1, 32'hFFFF_FFF7, 8'd7},  // R7 mask set
      '{8'd0, 1'b0, 16'h0004, 32'h0, 1'b1, 32'h0000_0000, 8'd7},  // R7
      '{8'd0, 1'b1, 16'h0280, 32'h20, 1'b0, 32'h0, 8'd4},
      '{8'd1, 1'b1, 16'h0284, 32'h100, 1'b0, 32'h0, 8'd4},
      '{8'd0, 1'b0, 16'h0204, 32'h0, 1'b1, 32'h0000_0000, 8'd4},  // R4 clear
      '{8'd1, 1'b1, 16'h0200, 32'h8, 1'b0, 32'h0, 8'd4},          // soft line 3
      '{8'd0, 1'b0, 16'h0004, 32'h0, 1'b1, 32'h0000_0000, 8'd6},  // R6 not routed
      '{8'd1, 1'b0, 16'h0004, 32'h0, 1'b1, 32'h0001_0003, 8'd6},  // R6
      '{8'd1, 1'b1, 16'h0280, 32'h8, 1'b0, 32'h0, 8'd4},
      '{8'd0, 1'b1, 16'h0100, 32'h0, 1'b0, 32'h0, 8'd3},          // zero write
      '{8'd0, 1'b0, 16'h0100, 32'h0, 1'b1, 32'hFFFF_FFFF, 8'd3},  // R3 zeros ignored
      '{8'd1, 1'b0, 16'h0180, 32'h0, 1'b1, 32'hFFFF_FFFF, 8'd3},  // R3
      '{8'd0, 1'b1, 16'h0180, 32'h20, 1'b0, 32'h0, 8'd3},
      '{8'd1, 1'b1, 16'h0184, 32'h100, 1'b0, 32'h0, 8'd3},
      '{8'd0, 1'b1, 16'h1014, 32'h3, 1'b0, 32'h0, 8'd5}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NL-1:0]    irq_line = '0;
   logic [NC-1:0]    bus_sel = '0;
   logic [NC-1:0]    bus_wr = '0;
   logic [NC*16-1:0] bus_addr = '0;
   logic [NC*32-1:0] bus_wdata = '0;
   logic [NC*32-1:0] bus_rdata;
   logic [NC-1:0]    irq_out;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_irq_ctrl #(.NUM_LINES(NL), .NUM_CPUS(NC)) dut (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", what, act, exp);
      end
   endtask

   task automatic op(input int cpu, input logic wr, input logic [15:0] addr,
                     input logic [31:0] wdata, output logic [31:0] rdata);
      bus_sel[cpu] = 1'b1;
      bus_wr[cpu]  = wr;
      bus_addr[cpu*16 +: 16]  = addr;
      bus_wdata[cpu*32 +: 32] = wdata;
      @(posedge clk);
      @(negedge clk);
      bus_sel = '0;
      bus_wr  = '0;
      rdata = bus_rdata[cpu*32 +: 32];
   endtask

   task automatic pair_event(output logic [31:0] d0, output logic [31:0] d1);
      bus_sel  = 2'b11;
      bus_wr   = 2'b00;
      bus_addr = {16'h0004, 16'h0004};
      @(posedge clk);
      @(negedge clk);
      bus_sel = '0;
      d0 = bus_rdata[31:0];
      d1 = bus_rdata[63:32];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, d0, d1;
      repeat (3) @(negedge clk);
      check({30'h0, irq_out}, 32'h0, "R2 irq_out low after reset");
      rst_n = 1'b1;
      @(negedge clk);
      check({30'h0, irq_out}, 32'h0, "R2 irq_out low out of reset");

      for (int i = 0; i < NV; i++) begin
         op(int'(VEC[i].cpu), VEC[i].wr, VEC[i].addr, VEC[i].wdata, d);
         if (VEC[i].chk) begin
            tests++;
            if (d !== VEC[i].exp) begin
               fails++;
               $display("FAIL R%0d vector %0d: actual %08h expected %08h",
                        VEC[i].req, i, d, VEC[i].exp);
            end
         end
      end

      // R8: hardware lines 5 and 40 requesting, both unmasked and routed to both CPUs
      irq_line[5] = 1'b1; irq_line[40] = 1'b1;
      @(negedge clk);
      check({30'h0, irq_out}, 32'h3, "R8 both outputs high");
      // R9: simultaneous event reads
      pair_event(d0, d1);
      check(d0, 32'h0001_0005, "R9 cpu0 gets lowest");
      check(d1, 32'h0001_0028, "R9 cpu1 gets next");
      check({30'h0, irq_out}, 32'h0, "R7 taken lines stay masked while high");
      op(0, 1'b1, 16'h0180, 32'h20, d);
      check({30'h0, irq_out}, 32'h3, "R8 unmasked line 5 raises both");
      pair_event(d0, d1);
      check(d0, 32'h0001_0005, "R9 cpu0 gets sole line");
      check(d1, 32'h0000_0000, "R9 cpu1 gets nothing");
      // R4: level-sensitive drop before being taken
      op(1, 1'b1, 16'h0180, 32'h20, d);
      irq_line[5] = 1'b0;
      @(negedge clk);
      check({30'h0, irq_out}, 32'h0, "R4 dropped line no longer requests");
      op(0, 1'b0, 16'h0004, 32'h0, d);
      check(d, 32'h0, "R4 dropped line not reported");
      // R10: read data hold
      op(0, 1'b0, 16'h0000, 32'h0, d);
      repeat (3) @(negedge clk);
      check(bus_rdata[31:0], 32'h0000_0040, "R10 data holds while idle");
      op(0, 1'b1, 16'h0100, 32'h0, d);
      check(d, 32'h0000_0040, "R10 write leaves read data");
      // R2: reset restores state
      op(0, 1'b1, 16'h0184, 32'h100, d);
      check({30'h0, irq_out}, 32'h3, "R8 line 40 raises both");
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({30'h0, irq_out}, 32'h0, "R2 outputs low after reset");
      op(1, 1'b0, 16'h0104, 32'h0, d);
      check(d, 32'hFFFF_FFFF, "R2 mask restored");
      op(0, 1'b0, 16'h10A0, 32'h0, d);
      check(d, 32'h0, "R2 route cleared");
      op(1, 1'b0, 16'h0004, 32'h0, d);
      check(d, 32'h0, "R2 event empty");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule